// File: doc/BRIEF.md
# Double-Buffered Pulse-Width Modulator

This block produces one pulse-width-modulated output from an 8-bit period setting and a 10-bit duty setting. Its time base is an 8-bit counter with two sub-count bits below it, so the duty value resolves a quarter of one counter step. A selectable prescaler (1, 4 or 16 input clocks per sub-count) stretches the whole waveform.

Software writes the duty value into a master register. A slave copy drives the comparison, and that copy is refreshed only when a period ends. Because of this, a duty change made in the middle of a period never produces a truncated or doubled pulse. While the generator is disabled, the slave follows the master and the time base is held at zero. Enabling the generator then starts a period at once, using the duty value already written. When disabled, the pin carries the ordinary port value. A separate drive-disable bit puts the pin in high impedance whether or not the generator runs.

Top module: `pwm_gen`

## Requirements
- R1: After reset the slave duty reads 0, the generator is off (the pin carries `port_latch`), and the drive-disable bit is set, so `pin_oe` is 0.
- R2: A write with `wr_en` high uses `wr_sel` as follows. Select 0 loads the period byte. Select 1 loads duty bits [9:2]. Select 2 loads duty bits [1:0] from `wr_data[1:0]`. Select 3 loads the control fields: bit 0 is run, bit 1 is drive-disable (1 = high impedance), and bits [3:2] are the prescale code (00 = 1, 01 = 4, 10 and 11 = 16).
- R3: While running, one period lasts (period + 1) × 4 × prescale input clocks.
- R4: Each period starts with the output high, unless the latched duty is 0. The output stays high for exactly duty × prescale clocks.
- R5: A latched duty greater than or equal to (period + 1) × 4 keeps the output high for the entire period.
- R6: A latched duty of 0 keeps the output low for the entire period.
- R7: A duty write made while running leaves the readable slave duty and the waveform unchanged for the rest of the current period. It takes effect from the next period.
- R8: While run is 0, `pin_out` equals `port_latch`, and the slave duty takes the master value one clock after each write.
- R9: `pin_oe` is the inverse of the drive-disable bit, whether or not the generator runs.
- R10: The clock edge that sets run starts a new period at count 0, with the output reflecting the duty written beforehand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| port_latch | input | 1 | Ordinary port value, driven on the pin when the generator is off |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin drive enable (0 = high impedance) |
| slave_duty | output | 10 | Read-only view of the latched duty |

## Verification
Directed cases cover duty 0, duty just below the period, duty equal to the period and duty above it. These distinguish the normal falling edge from the cases where the output is stuck low or stuck high. Mid-period duty changes are placed both before and after the falling edge of the current pulse, which separates double-buffered behaviour from direct loading. Each prescale code is used at least once, and randomized period, duty and prescale combinations compare the measured high time and the period boundaries against closed-form expectations.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD  = 2'd0,
    SEL_DUTY_HI = 2'd1,
    SEL_DUTY_LO = 2'd2,
    SEL_CTRL    = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic [1:0] ps_code;
    logic       drv_dis;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = 4;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2,
  localparam int DUTY_W = TMR_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [TMR_W-1:0]  wr_data,
  output logic [TMR_W-1:0]  period_q,
  output logic [DUTY_W-1:0] master_q,
  output ctrl_t             ctrl_q
);
  logic [TMR_W-1:0]  period_d;
  logic [DUTY_W-1:0] master_d;
  ctrl_t             ctrl_d;

  always_comb begin
    period_d = period_q;
    master_d = master_q;
    ctrl_d   = ctrl_q;
    if (wr_en) begin
      unique case (wr_sel_e'(wr_sel))
        SEL_PERIOD:  period_d = wr_data;
        SEL_DUTY_HI: master_d[DUTY_W-1:SUB_W] = wr_data;
        SEL_DUTY_LO: master_d[SUB_W-1:0] = wr_data[SUB_W-1:0];
        SEL_CTRL:    ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      master_q <= '0;
      ctrl_q   <= '{ps_code: 2'b00, drv_dis: 1'b1, run: 1'b0};
    end else begin
      period_q <= period_d;
      master_q <= master_d;
      ctrl_q   <= ctrl_d;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TMR_W  = 8,
  parameter int SUB_W  = 2,
  parameter int PS_MID = 2,
  parameter int PS_MAX = 4,
  localparam int DUTY_W = TMR_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        ps_code,
  input  logic [TMR_W-1:0]  period,
  output logic [DUTY_W-1:0] base_q,
  output logic              tick,
  output logic              wrap
);
  localparam logic [PS_MAX-1:0] LIM_MID = PS_MAX'((1 << PS_MID) - 1);
  localparam logic [PS_MAX-1:0] LIM_MAX = PS_MAX'((1 << PS_MAX) - 1);

  logic [PS_MAX-1:0] presc_q, presc_d, lim;
  logic [DUTY_W-1:0] base_d, last;

  always_comb begin
    unique case (ps_code)
      2'b00:   lim = '0;
      2'b01:   lim = LIM_MID;
      default: lim = LIM_MAX;
    endcase
  end

  assign last = {period, {SUB_W{1'b1}}};
  assign tick = run & (presc_q >= lim);
  assign wrap = tick & (base_q >= last);

  always_comb begin
    if (!run || tick) presc_d = '0;
    else              presc_d = presc_q + 1'b1;
    if (!run || wrap) base_d = '0;
    else if (tick)    base_d = base_q + 1'b1;
    else              base_d = base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      base_q  <= '0;
    end else begin
      presc_q <= presc_d;
      base_q  <= base_d;
    end
  end
endmodule

// File: rtl/pwm_duty.sv
module pwm_duty #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] base_q,
  input  logic [DUTY_W-1:0] master,
  output logic [DUTY_W-1:0] slave_q,
  output logic              pwm_q
);
  logic [DUTY_W-1:0] slave_d, base_inc;
  logic              pwm_d, reload;

  assign reload   = !run || wrap;
  assign base_inc = base_q + 1'b1;

  always_comb begin
    slave_d = reload ? master : slave_q;
    if (reload)                        pwm_d = (master != '0);
    else if (tick && base_inc == slave_q) pwm_d = 1'b0;
    else                               pwm_d = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      slave_q <= slave_d;
      pwm_q   <= pwm_d;
    end
  end
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int SUB_W  = 2,
  parameter int PS_MID = 2,
  parameter int PS_MAX = 4,
  localparam int DUTY_W = TMR_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [TMR_W-1:0]  wr_data,
  input  logic              port_latch,
  output logic              pin_out,
  output logic              pin_oe,
  output logic [DUTY_W-1:0] slave_duty
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [TMR_W-1:0]  period_q;
  logic [DUTY_W-1:0] master_q, base_q, slave_q;
  ctrl_t             ctrl_q;
  logic              run_en, tick, wrap, pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pwm_regs #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .period_q(period_q), .master_q(master_q), .ctrl_q(ctrl_q)
  );

  assign run_en = ctrl_q.run;

  pwm_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W), .PS_MID(PS_MID), .PS_MAX(PS_MAX)) u_tb (
    .clk(clk), .rst_n(rst_int_n), .run(run_en), .ps_code(ctrl_q.ps_code),
    .period(period_q), .base_q(base_q), .tick(tick), .wrap(wrap)
  );

  pwm_duty #(.DUTY_W(DUTY_W)) u_duty (
    .clk(clk), .rst_n(rst_int_n), .run(run_en), .tick(tick), .wrap(wrap),
    .base_q(base_q), .master(master_q), .slave_q(slave_q), .pwm_q(pwm_q)
  );

  assign pin_out    = run_en ? pwm_q : port_latch;
  assign pin_oe     = ~ctrl_q.drv_dis;
  assign slave_duty = slave_q;
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              wrap,
  input logic              pwm,
  input logic              pin_out,
  input logic [DUTY_W-1:0] base,
  input logic [DUTY_W-1:0] slave,
  input logic [DUTY_W-1:0] master
);
  // R4/R5/R6: the output is high exactly while the count is below the latched duty
  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    pwm == (base < slave));

  // R4: a period boundary reloads the output from the incoming duty
  a_r4_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap) |=> (pwm == (slave != '0)));

  // R3: the count restarts from zero after a period boundary
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (base == '0));

  // R7: the latched duty only moves at a boundary while running
  a_r7_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(slave));

  // R6: zero duty keeps the pin low while running
  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run && slave == '0) |-> !pin_out);

  // R8: while stopped the count is held and the slave tracks the master
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (base == '0 && slave == $past(master)));
endmodule

bind pwm_gen pwm_gen_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .run(run_en), .wrap(wrap), .pwm(pwm_q),
  .pin_out(pin_out), .base(base_q), .slave(slave_q), .master(master_q)
);

// File: tb/pwm_gen_test.sv
module pwm_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       port_latch = 1'b1;
  logic       pin_out, pin_oe;
  logic [9:0] slave_duty;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwm_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .port_latch(port_latch), .pin_out(pin_out), .pin_oe(pin_oe), .slave_duty(slave_duty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ps_factor(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : 16;
  endfunction

  function automatic int exp_high(input int duty, input int n, input int p);
    return ((duty < n) ? duty : n) * p;
  endfunction

  // Runs nper periods; if chg_at >= 0 a new duty d2 is written at that cycle of period 0
  task automatic run_case(input int pr, input int ps, input int d1, input int d2,
                          input int chg_at, input int nper);
    int n   = (pr + 1) * 4;
    int p   = ps_factor(ps);
    int per = n * p;
    int hi[4];
    for (int i = 0; i < 4; i++) hi[i] = 0;
    wr(3, ps << 2);
    wr(0, pr);
    wr(1, d1 >> 2);
    wr(2, d1 & 3);
    wr(3, (ps << 2) | 1);
    for (int cyc = 0; cyc < nper * per; cyc++) begin
      int idx  = cyc / per;
      int dcur = (chg_at >= 0 && idx >= 1) ? d2 : d1;
      if (cyc % per == 0) begin
        // R10 / R3: a period begins here with the output reflecting the latched duty
        chk(pin_out == (dcur != 0), (cyc == 0) ? "R10 start level" : "R3 period boundary",
            int'(pin_out), int'(dcur != 0));
        chk(slave_duty == 10'(dcur), "R7 slave at boundary", int'(slave_duty), dcur);
      end
      if (cyc == 0) chk(pin_oe == 1'b1, "R9 drive enabled", int'(pin_oe), 1);
      if (pin_out) hi[idx]++;
      if (chg_at >= 0 && cyc == chg_at + 2)
        chk(slave_duty == 10'(d1), "R7 slave held mid-period", int'(slave_duty), d1);
      if (chg_at >= 0 && cyc == chg_at) begin
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'(d2 >> 2);
      end else if (chg_at >= 0 && cyc == chg_at + 1) begin
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'(d2 & 3);
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    for (int i = 0; i < nper; i++) begin
      int dcur = (chg_at >= 0 && i >= 1) ? d2 : d1;
      string tag = (dcur == 0) ? "R6 zero duty" : (dcur >= n) ? "R5 full duty" :
                   (i >= 1 && chg_at >= 0) ? "R7 new duty next period" : "R4 high time";
      chk(hi[i] == exp_high(dcur, n, p), tag, hi[i], exp_high(dcur, n, p));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pin_oe == 1'b0, "R1 oe after reset", int'(pin_oe), 0);
    chk(pin_out == 1'b1, "R1 pin shows port latch", int'(pin_out), 1);
    chk(slave_duty == 10'd0, "R1 slave after reset", int'(slave_duty), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pin_oe == 1'b0, "R1 oe off after release", int'(pin_oe), 0);

    // R8: stopped generator passes the port latch, slave follows master
    port_latch = 1'b0;
    @(negedge clk);
    chk(pin_out == 1'b0, "R8 pin follows latch low", int'(pin_out), 0);
    port_latch = 1'b1;
    @(negedge clk);
    chk(pin_out == 1'b1, "R8 pin follows latch high", int'(pin_out), 1);
    wr(1, 8'hA5);
    wr(2, 2);
    @(negedge clk);
    chk(slave_duty == 10'h296, "R8 slave tracks master", int'(slave_duty), 10'h296);

    // R9: drive-disable independent of run
    wr(3, 32'h3);
    chk(pin_oe == 1'b0, "R9 hi-z while running", int'(pin_oe), 0);
    wr(3, 32'h0);
    chk(pin_oe == 1'b1, "R9 driven while stopped", int'(pin_oe), 1);

    // directed corners (R2 prescale codes, R4, R5, R6)
    run_case(9, 0, 13, 0, -1, 2);
    run_case(9, 0, 0, 0, -1, 2);
    run_case(9, 0, 39, 0, -1, 2);
    run_case(9, 0, 40, 0, -1, 2);
    run_case(9, 0, 45, 0, -1, 2);
    run_case(3, 1, 7, 0, -1, 2);
    run_case(2, 2, 5, 0, -1, 2);
    run_case(2, 3, 11, 0, -1, 2);
    run_case(255, 0, 1000, 0, -1, 1);
    // R7: mid-period change after and before the falling edge
    run_case(9, 0, 20, 7, 25, 3);
    run_case(9, 0, 30, 5, 2, 3);
    run_case(4, 1, 3, 19, 40, 3);
    run_case(9, 0, 0, 40, 10, 3);

    // randomized mix
    for (int t = 0; t < 12; t++) begin
      int pr = int'($urandom_range(0, 15));
      int ps = int'($urandom_range(0, 3));
      int n  = (pr + 1) * 4;
      int d1 = int'($urandom_range(0, n + 6));
      int d2 = int'($urandom_range(0, n + 6));
      int per = n * ps_factor(ps);
      int ch = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, per - 3)) : -1;
      run_case(pr, ps, d1, d2, ch, 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule